// File: doc/BRIEF.md
# Noise-Shaped Phase Truncation DDS

This core is the digital front end of a direct digital synthesizer. On every enabled clock a frequency tuning word is added into a 16-bit phase register that wraps around. The phase is then cut down to an 8-bit table address. Plain truncation would leave periodic spurs in the output. Instead, a fourth-order error-feedback loop pushes the truncation error into high frequencies, where a later filter can remove it. The shaped 8-bit phase selects one of 256 signed 12-bit amplitude words. The table is therefore sixteen times smaller than one addressed by 12 phase bits.

The loop has a single stage and keeps only registered error history, so it accepts one new phase per clock. The table contents are computed when the design is elaborated. The amplitude register drives a converter outside this block. A valid flag marks the samples that carry real data. Holding the enable low freezes the whole datapath.

Top module: `dds_ns_core`

## Requirements
- R1: The phase register is 16 bits wide. On each enabled clock it becomes (phase + tuning word) mod 65536.
- R2: On each enabled clock the shaper takes x = the upper 12 bits of the phase register as it stood before that edge. It forms v = (x - (4*e1 - 6*e2 + 4*e3 - e4)) mod 4096, where e1..e4 are its four most recent errors, newest first. It stores the shaped phase v >> 4 (bits 11:4 of v) and pushes a new error e = -(v mod 16).
- R3: The table entry for 8-bit phase p is computed as follows. Let u = p mod 128 and m = floor(2047*16*u*(128-u) / (81920 - 4*u*(128-u))). The entry is m in two's complement for p < 128 and -m for p >= 128. The code -2048 never appears.
- R4: After enabled edge n, the amplitude output is the table entry of the shaped phase stored at enabled edge n-1, giving one sample per enabled clock.
- R5: While enable is low, the phase register, the shaper state, the amplitude and the valid flag all hold their values.
- R6: Synchronous active-high reset clears the phase register, the shaper error history, the shaped phase and the amplitude to zero, and drops the valid flag.
- R7: Starting from reset, a tuning word of zero keeps the amplitude at zero. In any state, an enabled clock with a zero tuning word leaves the phase register unchanged.
- R8: The valid flag rises after the second enabled clock that follows reset and stays high until the next reset. A change of tuning word neither clears it nor restarts the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the datapath by one sample |
| ftw | input | 16 | Frequency tuning word added to the phase each enabled clock |
| amp | output | 12 | Signed two's-complement sine amplitude |
| amp_vld | output | 1 | High once the amplitude carries shaped data |

## Verification
The bench goes after phase wrap-around: a step of half a turn and a near-full-turn step that acts as a negative frequency. A design that used signed or saturating phase arithmetic would jump to the wrong table half. Slow tuning words leave nonzero low bits, which exercises the error history. A wrong sign or a misordered binomial weight makes the shaped phase drift away from the accumulator. A one-slot shift in the history leaves the sequence close to correct but still different from the expected one. Irregular enable gaps and a mid-run reset check that a stalled design neither advances nor dithers, and that a reset leaves no stale error terms behind.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int ACC_W     = 16;
    localparam int SHP_IN_W  = 12;
    localparam int PH_W      = 8;
    localparam int AMP_W     = 12;
    localparam int NS_ORDER  = 4;
    localparam int TBL_DEPTH = 1 << PH_W;
    localparam int AMP_PEAK  = (1 << (AMP_W - 1)) - 1;

    typedef struct packed {
        logic ph_vld;
        logic amp_vld;
    } stage_vld_t;

    function automatic int binom(input int n, input int k);
        int r;
        r = 1;
        for (int i = 1; i <= k; i++) begin
            r = r * (n - k + i) / i;
        end
        return r;
    endfunction

    function automatic logic signed [AMP_W-1:0] sine_val(input int idx);
        int half_n;
        int u;
        int prod;
        int mag;
        half_n = TBL_DEPTH / 2;
        u      = idx % half_n;
        prod   = u * (half_n - u);
        mag    = (AMP_PEAK * 16 * prod) / (5 * half_n * half_n - 4 * prod);
        if (idx >= half_n) begin
            mag = -mag;
        end
        return AMP_W'(mag);
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
    import dds_pkg::*;
#(
    parameter int W = ACC_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] step,
    output logic [W-1:0] phase
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (en) begin
            phase <= phase + step;
        end
    end

endmodule

// File: rtl/dds_ns_shaper.sv
module dds_ns_shaper
    import dds_pkg::*;
#(
    parameter int IN_W  = SHP_IN_W,
    parameter int OUT_W = PH_W,
    parameter int ORDER = NS_ORDER
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [IN_W-1:0]  x,
    output logic [OUT_W-1:0] q
);

    localparam int DROP  = IN_W - OUT_W;
    localparam int ERR_W = DROP + 1;
    localparam int FB_W  = ERR_W + ORDER + 1;

    logic signed [ERR_W-1:0] e_hist [ORDER];
    logic signed [FB_W-1:0]  fb;
    logic signed [FB_W-1:0]  terms [ORDER];
    logic [IN_W-1:0]         v;
    logic signed [ERR_W-1:0] e_new;

    // Weight k of the loop filter is (-1)^(k+1) * C(ORDER, k), which gives
    // a noise transfer of (1 - z^-1)^ORDER.
    for (genvar k = 0; k < ORDER; k++) begin : g_tap
        localparam int MAG  = binom(ORDER, k + 1);
        localparam int COEF = (k % 2 == 0) ? MAG : -MAG;
        assign terms[k] = FB_W'(COEF * int'(e_hist[k]));
    end

    always_comb begin
        fb = '0;
        for (int k = 0; k < ORDER; k++) begin
            fb = fb + terms[k];
        end
    end

    assign v     = x - IN_W'(fb);
    assign e_new = ERR_W'(-$signed({1'b0, v[DROP-1:0]}));

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
            for (int k = 0; k < ORDER; k++) begin
                e_hist[k] <= '0;
            end
        end else if (en) begin
            q         <= v[IN_W-1:DROP];
            e_hist[0] <= e_new;
            for (int k = 1; k < ORDER; k++) begin
                e_hist[k] <= e_hist[k-1];
            end
        end
    end

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom
    import dds_pkg::*;
#(
    parameter int AW = PH_W,
    parameter int DW = AMP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [AW-1:0]        addr,
    output logic signed [DW-1:0] data
);

    localparam int DEPTH = 1 << AW;

    logic signed [DW-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic signed [DW-1:0] VAL = DW'(sine_val(i));
        assign tbl[i] = VAL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (en) begin
            data <= tbl[addr];
        end
    end

endmodule

// File: rtl/dds_ns_core.sv
module dds_ns_core
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] ftw,
    output logic [AMP_W-1:0] amp,
    output logic             amp_vld
);

    logic [ACC_W-1:0]        acc_q;
    logic [PH_W-1:0]         ph_q;
    logic signed [AMP_W-1:0] amp_q;
    stage_vld_t              vld_q;

    dds_phase_acc #(.W(ACC_W)) u_acc (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .step  (ftw),
        .phase (acc_q)
    );

    dds_ns_shaper #(
        .IN_W  (SHP_IN_W),
        .OUT_W (PH_W),
        .ORDER (NS_ORDER)
    ) u_shp (
        .clk (clk),
        .rst (rst),
        .en  (en),
        .x   (acc_q[ACC_W-1 -: SHP_IN_W]),
        .q   (ph_q)
    );

    dds_sine_rom #(.AW(PH_W), .DW(AMP_W)) u_rom (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .addr (ph_q),
        .data (amp_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (en) begin
            vld_q.ph_vld  <= 1'b1;
            vld_q.amp_vld <= vld_q.ph_vld;
        end
    end

    assign amp     = amp_q;
    assign amp_vld = vld_q.amp_vld;

endmodule

// File: rtl/dds_ns_core_chk.sv
module dds_ns_core_chk
    import dds_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [ACC_W-1:0] ftw,
    input logic [ACC_W-1:0] acc,
    input logic [PH_W-1:0]  ph,
    input logic [AMP_W-1:0] amp,
    input logic             amp_vld
);

    localparam logic [AMP_W-1:0] AMP_MIN = {1'b1, {(AMP_W-1){1'b0}}};

    p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
        en |=> acc == $past(acc + ftw));

    p_amp_range_r3: assert property (@(posedge clk) disable iff (rst)
        amp_vld |-> amp != AMP_MIN);

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(acc) && $stable(ph) && $stable(amp) && $stable(amp_vld)));

    p_reset_clear_r6: assert property (@(posedge clk)
        rst |=> (acc == '0 && ph == '0 && amp == '0 && !amp_vld));

    p_zero_step_r7: assert property (@(posedge clk) disable iff (rst)
        (en && ftw == '0) |=> $stable(acc));

    p_valid_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        amp_vld |=> amp_vld);

endmodule

bind dds_ns_core dds_ns_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .ftw     (ftw),
    .acc     (acc_q),
    .ph      (ph_q),
    .amp     (amp),
    .amp_vld (amp_vld)
);

// File: tb/dds_ns_core_bench.sv
module dds_ns_core_bench;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        vld;
        int          amp;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [15:0] ftw = '0;
    logic [11:0] amp;
    logic        amp_vld;

    int   n_chk  = 0;
    int   n_fail = 0;
    exp_t sb[$];

    // reference state
    int m_acc;
    int m_ph;
    int m_amp;
    int m_err [4];
    int m_v1;
    int m_v2;

    dds_ns_core u_dds_ns_core (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .ftw     (ftw),
        .amp     (amp),
        .amp_vld (amp_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ref_sine(input int p);
        int u;
        int m;
        u = p % 128;
        m = (2047 * 16 * u * (128 - u)) / (81920 - 4 * u * (128 - u));
        return (p >= 128) ? -m : m;
    endfunction

    task automatic model_reset();
        m_acc = 0; m_ph = 0; m_amp = 0; m_v1 = 0; m_v2 = 0;
        for (int k = 0; k < 4; k++) m_err[k] = 0;
    endtask

    task automatic model_step(input int step);
        int x;
        int fbk;
        int v;
        m_amp = ref_sine(m_ph);
        x   = m_acc / 16;
        fbk = 4*m_err[0] - 6*m_err[1] + 4*m_err[2] - m_err[3];
        v   = ((x - fbk) % 4096 + 4096) % 4096;
        m_ph = v / 16;
        m_err[3] = m_err[2]; m_err[2] = m_err[1]; m_err[1] = m_err[0];
        m_err[0] = -(v % 16);
        m_acc = (m_acc + step) % 65536;
        m_v2 = m_v1; m_v1 = 1;
    endtask

    // driver: one clock of stimulus, expected result queued
    task automatic drive(input logic e, input int step, input string tag);
        exp_t it;
        @(negedge clk);
        en  = e;
        ftw = 16'(step);
        if (e) model_step(step);
        it.vld = 1'(m_v2);
        it.amp = m_amp;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        en  = 1'b0;
        sb.delete();
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_chk++;
        if (amp !== 12'd0 || amp_vld !== 1'b0) begin
            n_fail++;
            $display("FAIL R6 reset state: amp=%0d vld=%0b expected amp=0 vld=0",
                     $signed(amp), amp_vld);
        end
    endtask

    // monitor: compare one queued item after every edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                n_chk++;
                if (amp_vld !== it.vld || int'($signed(amp)) != it.amp) begin
                    n_fail++;
                    $display("FAIL %s: amp=%0d vld=%0b expected amp=%0d vld=%0b",
                             it.tag, $signed(amp), amp_vld, it.amp, it.vld);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R7: zero step from reset keeps amplitude at zero; R8 valid rises
        for (int i = 0; i < 20; i++) drive(1'b1, 0, "R7/R8 zero step");

        // R2/R4: step with clean low bits, then with dithered low bits
        for (int i = 0; i < 300; i++) drive(1'b1, 16'h0010, "R2/R4 unit phase step");
        for (int i = 0; i < 400; i++) drive(1'b1, 16'h0123, "R2/R4 mid step");
        for (int i = 0; i < 600; i++) drive(1'b1, 16'h0007, "R2 slow dithered step");

        // R8: tuning word change without restart
        for (int i = 0; i < 200; i++) drive(1'b1, 16'h0a5b, "R8 word change");

        // R1: half-turn and negative-frequency wraps
        for (int i = 0; i < 100; i++) drive(1'b1, 16'h8000, "R1 half-turn wrap");
        for (int i = 0; i < 300; i++) drive(1'b1, 16'hffe9, "R1 reverse wrap");
        for (int i = 0; i < 200; i++) drive(1'b1, 16'h3fff, "R1/R3 quarter step");

        // R7: zero step mid-run holds phase, shaper may still settle
        for (int i = 0; i < 60; i++) drive(1'b1, 0, "R7 held phase");

        // R5: irregular enable gaps
        for (int i = 0; i < 400; i++) drive(1'(((i * 7) % 5) < 2), 16'h0531, "R5 stall hold");

        // R6: reset mid-run, then run again from clean state
        do_reset();
        for (int i = 0; i < 3; i++) drive(1'b0, 16'h1234, "R5/R8 idle after reset");
        for (int i = 0; i < 300; i++) drive(1'b1, 16'h0f0d, "R6/R4 restart");

        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule